// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a byte-wide memory on an open-drain two-wire bus. A fast system clock oversamples the clock line and the data line. The block finds start and stop conditions in those samples and compares the select field of each address byte with its select inputs. It acknowledges the bytes it accepts by pulling the data line low. Writes are taken in as sector program transfers. Read data are shifted out of an internal byte RAM.

A write transfer fills a sector-sized staging buffer. The stop condition starts a timed internal program cycle, which copies the buffer into the RAM. While that cycle runs, the slave does not respond on the bus, so a master finds out that programming has finished by polling for the acknowledge of its address byte. Reads come in three forms: from the current address, from an address loaded by a header-only write, or as a sequential run that continues for as long as the master acknowledges. Before it accepts each data byte, the block asks a separate protection block whether the target address may be programmed.

Top module: `tw_serial_mem`

## Requirements
- R1: After reset the data-line pull-down is off. A start condition (data falling while the clock is high) begins a new transfer, also as a repeated start in the middle of a transfer.
- R2: Address byte layout: bits [7:4] are the select field, bits [3:1] are byte-address bits 10..8, and bit 0 selects the operation (1 read, 0 write). If the select field differs from `sel_i`, the slave sends no acknowledge and stays off the bus until the next start.
- R3: Every accepted byte is acknowledged by holding the data line low through the ninth clock. The pull-down changes only while the clock line is low.
- R4: A write is an address byte followed by data bytes. After each data byte only byte-address bits 4..0 advance, wrapping inside the 32-byte sector, and bits 10..5 stay fixed.
- R5: A stop that follows at least one accepted data byte starts a program cycle of PROG_CYCLES clocks that writes the sector. During that cycle the slave acknowledges nothing, including its own address byte.
- R6: A random read is a write header with no data, then a repeated start and a read address byte. It programs nothing, and the slave can be addressed again at once.
- R7: Read bytes are sent MSB first. An acknowledge from the master brings the next byte. A non-acknowledge releases the data line until the next start.
- R8: The read address advances across all 11 bits and wraps from 0x7FF to 0x000.
- R9: A read with no address header continues at the location after the last byte sent.
- R10: `pq_addr_o` carries the byte address that the next data byte will be written to. If `pq_deny_i` is high when that byte completes, the byte is not acknowledged and the whole transfer is dropped without a program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sel_i | input | SEL_W | Select value that the address byte must match |
| pq_deny_i | input | 1 | Protection answer: high forbids programming `pq_addr_o` |
| sda_pull_o | output | 1 | Data-line pull-down enable, registered |
| pq_addr_o | output | ADDR_W | Byte address presented to the protection block |

## Verification
Writes are run three ways: a full 32-byte transfer that starts in the middle of a sector, so the wrap of the low address bits shows in the stored data; a transfer with a mismatched select field; and a transfer that the protection block refuses, which must leave the old contents in place. Reads cover a header-loaded random read, a current-address read after a partial read, a sequential read that crosses the top of the address space, and a non-acknowledged read followed by extra clocks. These tell apart the five-bit write increment from the full read increment, and a dropped transfer from a programmed one. Address polling right after a stop separates a header-only write from a write that carried data.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_WORDADR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_RLOAD,
    ST_HOLD,
    ST_PROG
  } tw_state_e;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_q;
  logic sda_q;
  logic scl_s;
  logic sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_sector_buf.sv
module tw_sector_buf #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/tw_byte_ram.sv
module tw_byte_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/tw_serial_mem.sv
module tw_serial_mem
  import tw_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int SECTOR_BYTES = 32,
  parameter int PROG_CYCLES  = 500000,
  parameter int SYNC_STAGES  = 2,
  localparam int SEL_W       = 15 - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              pq_deny_i,
  output logic              sda_pull_o,
  output logic [ADDR_W-1:0] pq_addr_o
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int SEC_W = $clog2(SECTOR_BYTES);
  localparam int PCW   = $clog2(PROG_CYCLES);

  logic det_sda, det_rise, det_fall, det_start, det_stop;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(det_sda), .scl_rise_o(det_rise), .scl_fall_o(det_fall),
    .start_o(det_start), .stop_o(det_stop)
  );

  tw_state_e         state, nxt;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [6:0]        txsh;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0]   hi_q;
  logic              pend;
  logic              pull;
  logic [PCW-1:0]    pcnt;
  logic              busy;
  logic              byte_done;
  logic              take_data;
  logic              mem_we;
  logic [7:0]        buf_rdata;
  logic [7:0]        ram_rdata;

  assign busy      = (state == ST_PROG);
  assign byte_done = det_fall && (bitcnt == 4'd8);
  assign take_data = (state == ST_WDATA) && byte_done && !pq_deny_i;
  assign mem_we    = busy && (pcnt < PCW'(SECTOR_BYTES));

  tw_sector_buf #(.DEPTH(SECTOR_BYTES)) u_buf (
    .clk(clk), .we(take_data), .waddr(ptr[SEC_W-1:0]), .wdata(shreg),
    .raddr(pcnt[SEC_W-1:0]), .rdata(buf_rdata)
  );

  tw_byte_ram #(.AW(ADDR_W)) u_ram (
    .clk(clk), .we(mem_we),
    .waddr({ptr[ADDR_W-1:SEC_W], pcnt[SEC_W-1:0]}),
    .wdata(buf_rdata), .raddr(ptr), .rdata(ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      nxt    <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txsh   <= '0;
      ptr    <= '0;
      hi_q   <= '0;
      pend   <= 1'b0;
      pull   <= 1'b0;
      pcnt   <= '0;
    end else if (busy) begin
      // timed program cycle: bus is ignored entirely
      if (pcnt == PCW'(PROG_CYCLES - 1)) begin
        state <= ST_IDLE;
        pcnt  <= '0;
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end else if (det_start) begin
      state  <= ST_DEVADR;
      bitcnt <= '0;
      pend   <= 1'b0;
      pull   <= 1'b0;
    end else if (det_stop) begin
      pull   <= 1'b0;
      bitcnt <= '0;
      pend   <= 1'b0;
      pcnt   <= '0;
      state  <= pend ? ST_PROG : ST_IDLE;
    end else begin
      case (state)
        ST_DEVADR, ST_WORDADR, ST_WDATA: begin
          if (det_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], det_sda};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            if (state == ST_DEVADR) begin
              if (shreg[7 -: SEL_W] == sel_i) begin
                pull  <= 1'b1;
                state <= ST_ACK;
                nxt   <= shreg[0] ? ST_RDATA : ST_WORDADR;
                hi_q  <= shreg[HI_W:1];
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WORDADR) begin
              ptr   <= {hi_q, shreg};
              pull  <= 1'b1;
              state <= ST_ACK;
              nxt   <= ST_WDATA;
            end else if (pq_deny_i) begin
              pend  <= 1'b0;
              state <= ST_HOLD;
            end else begin
              pend  <= 1'b1;
              pull  <= 1'b1;
              state <= ST_ACK;
              nxt   <= ST_WDATA;
              ptr[SEC_W-1:0] <= ptr[SEC_W-1:0] + SEC_W'(1);
            end
          end
        end
        ST_ACK, ST_RLOAD: begin
          if (det_fall) begin
            bitcnt <= '0;
            if (state == ST_RLOAD || nxt == ST_RDATA) begin
              txsh  <= ram_rdata[6:0];
              pull  <= ~ram_rdata[7];
              ptr   <= ptr + 1'b1;
              state <= ST_RDATA;
            end else begin
              pull  <= 1'b0;
              state <= nxt;
            end
          end
        end
        ST_RDATA: begin
          if (det_fall) begin
            if (bitcnt == 4'd7) begin
              pull   <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RACK;
            end else begin
              pull   <= ~txsh[6];
              txsh   <= {txsh[5:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (det_rise) state <= det_sda ? ST_HOLD : ST_RLOAD;
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull;
  assign pq_addr_o  = ptr;
endmodule

// File: rtl/tw_serial_mem_chk.sv
module tw_serial_mem_chk #(
  parameter int PROG_CYCLES = 32
) (
  input logic clk,
  input logic rst,
  input logic sda_pull_o,
  input logic scl_fall,
  input logic stop_seen,
  input logic busy
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= 0;
    else     busy_run <= busy ? busy_run + 1 : 0;
  end

  // R3 / R7: pull-down moves only right after a detected clock fall
  a_r3_pull_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> $past(scl_fall));

  // R5: no acknowledge while programming
  a_r5_silent_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_pull_o);

  // R5: program cycle is entered only on a stop
  a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_seen));

  // R5: program cycle lasts exactly PROG_CYCLES clocks
  a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_run == PROG_CYCLES);
endmodule

bind tw_serial_mem tw_serial_mem_chk #(.PROG_CYCLES(PROG_CYCLES)) i_chk (
  .clk(clk), .rst(rst), .sda_pull_o(sda_pull_o), .scl_fall(det_fall),
  .stop_seen(det_stop), .busy(busy)
);

// File: tb/test_tw_serial_mem.sv
module test_tw_serial_mem;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 400;
  localparam logic [3:0] DEV_SEL = 4'hA;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic pq_deny = 1'b0;
  logic sda_pull;
  logic [10:0] pq_addr;
  logic sda_line;

  assign sda_line = m_sda & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_serial_mem #(.ADDR_W(11), .SECTOR_BYTES(32), .PROG_CYCLES(PROG)) i_tw_serial_mem (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sel_i(DEV_SEL),
    .pq_deny_i(pq_deny), .sda_pull_o(sda_pull), .pq_addr_o(pq_addr)
  );

  int n_tests = 0;
  int n_fail = 0;
  int viol = 0;
  logic prev_pull = 1'b0;
  logic [7:0] mref [2048];
  int mptr = 0;

  // per-clock bus monitor: the pull-down may only move while the clock line is low (R3)
  always @(posedge clk) begin
    if (!rst) begin
      if (sda_pull !== prev_pull && m_scl) viol++;
      prev_pull <= sda_pull;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input int addr, input bit rw);
    logic [10:0] a = addr[10:0];
    return {DEV_SEL, a[10:8], rw};
  endfunction

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 37 + i * 13 + 5);
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; w(5); m_scl = 1'b1; w(10); m_sda = 1'b0; w(10); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(5); m_scl = 1'b1; w(10); m_sda = 1'b1; w(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      w(5); m_sda = b[i]; w(5); m_scl = 1'b1; w(10); m_scl = 1'b0;
    end
    w(5); m_sda = 1'b1; w(5); m_scl = 1'b1; w(5);
    acked = !sda_line;
    w(5); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(10); m_scl = 1'b1; w(5); b[i] = sda_line; w(5); m_scl = 1'b0;
    end
    w(5); m_sda = give_ack ? 1'b0 : 1'b1; w(5); m_scl = 1'b1; w(10); m_scl = 1'b0;
    w(5); m_sda = 1'b1;
  endtask

  task automatic write_bytes(input int addr, input int n, input int seed, input bit commit,
                             output bit hdr_ok, output int data_acks, output int pq_seen);
    bit a;
    logic [10:0] ad = addr[10:0];
    bus_start();
    send_byte(dev(addr, 1'b0), a); hdr_ok = a;
    send_byte(ad[7:0], a); hdr_ok &= a;
    pq_seen = int'(pq_addr);
    data_acks = 0;
    for (int i = 0; i < n; i++) begin
      send_byte(pat(seed, i), a);
      if (a) data_acks++;
    end
    bus_stop();
    if (commit)
      for (int i = 0; i < n; i++) mref[{ad[10:5], 5'(ad[4:0] + i)}] = pat(seed, i);
  endtask

  task automatic poll(output bit acked);
    bus_start(); send_byte(dev(0, 1'b0), acked); bus_stop();
  endtask

  task automatic read_run(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(b === mref[mptr], req, b, mref[mptr]);
      mptr = (mptr + 1) % 2048;
    end
  endtask

  task automatic rand_read(input int addr, input int n, input string req, input bit do_stop);
    bit a1, a2, a3;
    logic [10:0] ad = addr[10:0];
    bus_start(); send_byte(dev(addr, 1'b0), a1); send_byte(ad[7:0], a2);
    bus_start(); send_byte(dev(addr, 1'b1), a3);
    check(a1 && a2 && a3, "R1 repeated start header acked", {a1, a2, a3}, 3'b111);
    mptr = addr;
    read_run(n, req);
    if (do_stop) bus_stop();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    bit hok, a;
    int dacks, pqs;
    logic [7:0] b;
    w(10); rst = 1'b0; w(10);
    check(sda_pull === 1'b0, "R1 pull-down off after reset", sda_pull, 0);

    // R2: wrong select field, no acknowledge and silence afterwards
    bus_start();
    send_byte({~DEV_SEL, 3'b001, 1'b0}, a);
    check(!a, "R2 mismatched select not acked", a, 0);
    send_byte(8'h00, a);
    check(!a, "R2 silent after mismatch", a, 0);
    bus_stop();

    // R4: full sector starting mid-sector, wraps in low 5 bits; R10 query address
    write_bytes(11'h145, 32, 1, 1'b1, hok, dacks, pqs);
    check(hok, "R3 write header acked", hok, 1);
    check(dacks == 32, "R4 all 32 data bytes acked", dacks, 32);
    check(pqs == 11'h145, "R10 query address after header", pqs, 11'h145);

    // R5: polling during program cycle, then after it
    poll(a);
    check(!a, "R5 no ack during program cycle", a, 0);
    w(PROG + 50);
    poll(a);
    check(a, "R5 ack after program cycle", a, 1);

    // R6 / R4: random read of whole sector
    rand_read(11'h140, 32, "R4 sector contents with wrap", 1'b1);
    poll(a);
    check(a, "R6 header-only write starts no program cycle", a, 1);

    // R9: current address read continues after last byte
    rand_read(11'h141, 3, "R6 random read data", 1'b1);
    bus_start(); send_byte(dev(0, 1'b1), a);
    check(a, "R9 current read acked", a, 1);
    read_run(1, "R9 current address continues");
    bus_stop();

    // R8: sequential read across top of address space
    write_bytes(11'h7E0, 32, 2, 1'b1, hok, dacks, pqs);
    w(PROG + 50);
    write_bytes(11'h000, 32, 3, 1'b1, hok, dacks, pqs);
    w(PROG + 50);
    rand_read(11'h7FE, 4, "R8 read address rollover", 1'b1);

    // R7: non-acknowledge releases the line
    rand_read(11'h140, 1, "R7 single byte read", 1'b0);
    recv_byte(1'b0, b);
    check(b == 8'hFF, "R7 line released after nack", b, 8'hFF);
    bus_stop();

    // R10: protection denies the write
    pq_deny = 1'b1;
    write_bytes(11'h150, 4, 9, 1'b0, hok, dacks, pqs);
    pq_deny = 1'b0;
    check(hok, "R10 header still acked", hok, 1);
    check(dacks == 0, "R10 denied data not acked", dacks, 0);
    poll(a);
    check(a, "R10 denied transfer starts no program cycle", a, 1);
    rand_read(11'h150, 2, "R10 contents unchanged", 1'b1);

    check(viol == 0, "R3 pull-down changes only with clock low", viol, 0);
    finish_run();
  end
endmodule